// File: doc/BRIEF.md
# Immediate-placing integer ALU

This block is the integer execution unit of a small load/store processor. Each cycle it takes a 3-bit operation code and two 32-bit operands, and it returns a 32-bit result combinationally. It also owns the four condition flags: zero, negative, carry and overflow. The flags are captured at the next clock edge only when the flag-enable input is high. The stored carry feeds the add-with-carry and subtract-with-borrow operations.

The second operand can come from a register, or it can come from a 16-bit immediate. An immediate is placed in the low or the high half of the word by a placement bit. The other half is zero, except for AND, where it is all ones so that those bits of the first operand pass through. A move is an add with a zero operand, or an AND with an all-ones operand.

Shifts take a signed amount. A positive amount shifts left and a negative amount shifts right. A control bit picks a logical or an arithmetic right shift.

Top module: `imm_alu`

## Requirements
- R1: Code 000 gives a+b and code 010 gives a-b, both modulo 2^32.
- R2: Code 001 gives a+b+C and code 011 gives a-b-(1-C). C is the stored carry flag, where C=1 on a subtract means that no borrow occurred.
- R3: Code 100 gives a AND b, code 101 gives a OR b and code 110 gives a XOR b.
- R4: When reg_form=0, the second operand is built from the immediate. With imm_hi=0 it is {16'h0000, imm16}; with imm_hi=1 it is {imm16, 16'h0000}.
- R5: For code 100 with reg_form=0, the half of the word not covered by the immediate is filled with ones. The corresponding bits of the result therefore equal op_a.
- R6: After reset all four flags are 0. At a clock edge with flag_en=0 the flags keep their value, and the result is still produced.
- R7: At a clock edge with flag_en=1, Z takes (result==0) and N takes result[31]. C takes the carry out of bit 31 for add, and for subtract it is 1 exactly when no borrow occurred. V takes the signed overflow of the add or subtract. Codes 100 to 110 clear C and V.
- R8: Code 111 shifts op_a. The amount is the low 6 bits, read as two's complement (-31 to +31), of op_b when reg_form=1 or of imm16 when reg_form=0. A positive amount shifts left and a negative amount shifts right by its magnitude.
- R9: A right shift is arithmetic when imm_hi=1 in immediate form, or when shift_sel=5'b11000 in register form. It is logical when imm_hi=0 in immediate form, or when shift_sel=5'b10000 in register form.
- R10: On a shift with flag_en=1, C takes the last bit shifted out, or 0 for an amount of zero, and V is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| sub_op | input | 3 | Operation code |
| reg_form | input | 1 | 1: second operand from op_b; 0: from the immediate |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate value |
| imm_hi | input | 1 | Immediate placement; for an immediate shift, selects arithmetic |
| shift_sel | input | 5 | Shift type field in register form |
| flag_en | input | 1 | Capture the flags at the next edge |
| result | output | 32 | Combinational result |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The result port is combinational, so a wrong operand widening, fill or shift direction shows on result in the same cycle that the inputs are applied. A flag that is captured wrongly, or captured while flag_en is low, appears on the flag ports one edge later. Because the stored carry feeds the next add-with-carry or subtract-with-borrow, a corrupted carry then also shifts that later result by one. The bench keeps its own flag model across the whole run, so such an error is caught at the first flag check or at the first carry-dependent result after it.

// File: rtl/imm_alu.sv
module imm_alu #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sub_op,
  input  logic             reg_form,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic             imm_hi,
  input  logic [4:0]       shift_sel,
  input  logic             flag_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int SH_W  = $clog2(WIDTH) + 1;
  localparam int FILLW = WIDTH - IMM_W;

  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_ADDC = 3'b001;
  localparam logic [2:0] OP_SUB  = 3'b010;
  localparam logic [2:0] OP_SUBB = 3'b011;
  localparam logic [2:0] OP_AND  = 3'b100;
  localparam logic [2:0] OP_OR   = 3'b101;
  localparam logic [2:0] OP_XOR  = 3'b110;

  logic             is_and;
  logic [WIDTH-1:0] imm_ext, opnd_b, b_eff;
  logic             is_sub, cin;
  logic [WIDTH:0]   sum;
  logic             add_v;

  assign is_and  = (sub_op == OP_AND);
  assign imm_ext = imm_hi ? {imm16, {FILLW{is_and}}} : {{FILLW{is_and}}, imm16};
  assign opnd_b  = reg_form ? op_b : imm_ext;

  assign is_sub = sub_op[1];
  assign b_eff  = is_sub ? ~opnd_b : opnd_b;
  always_comb begin
    case (sub_op)
      OP_ADD:  cin = 1'b0;
      OP_SUB:  cin = 1'b1;
      default: cin = flag_c;
    endcase
  end
  assign sum   = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign add_v = (op_a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]);

  logic [SH_W-1:0] amt, mag;
  logic            sh_left, sh_arith;
  logic [WIDTH:0]  lw, rsrc, rw;

  assign amt      = reg_form ? op_b[SH_W-1:0] : imm16[SH_W-1:0];
  assign mag      = amt[SH_W-1] ? (~amt + 1'b1) : amt;
  assign sh_left  = !amt[SH_W-1];
  assign sh_arith = reg_form ? shift_sel[3] : imm_hi;
  assign lw       = {1'b0, op_a} << mag;
  assign rsrc     = {op_a, 1'b0};
  assign rw       = sh_arith ? $unsigned($signed(rsrc) >>> mag) : (rsrc >> mag);

  logic new_c, new_v;
  always_comb begin
    new_c = 1'b0;
    new_v = 1'b0;
    case (sub_op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        result = sum[WIDTH-1:0];
        new_c  = sum[WIDTH];
        new_v  = add_v;
      end
      OP_AND: result = op_a & opnd_b;
      OP_OR:  result = op_a | opnd_b;
      OP_XOR: result = op_a ^ opnd_b;
      default: begin
        result = sh_left ? lw[WIDTH-1:0] : rw[WIDTH:1];
        new_c  = sh_left ? lw[WIDTH] : rw[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (flag_en) begin
      flag_z <= (result == '0);
      flag_n <= result[WIDTH-1];
      flag_c <= new_c;
      flag_v <= new_v;
    end
  end

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable({flag_z, flag_n, flag_c, flag_v}));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (flag_z == ($past(result) == '0)) && (flag_n == $past(result[WIDTH-1])));

  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && sub_op[2] && (sub_op != 3'b111)) |=> (!flag_c && !flag_v));

  p_zero_shift_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && sub_op == 3'b111 && amt == '0) |=> (!flag_c && !flag_v));

  p_and_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_form && is_and) |->
      (imm_hi ? (result[FILLW-1:0] == op_a[FILLW-1:0])
              : (result[WIDTH-1:IMM_W] == op_a[WIDTH-1:IMM_W])));
endmodule

// File: tb/imm_alu_tb.sv
module imm_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sub_op = '0;
  logic        reg_form = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [15:0] imm16 = '0;
  logic        imm_hi = 1'b0;
  logic [4:0]  shift_sel = 5'b10000;
  logic        flag_en = 1'b0;
  logic [31:0] result;
  logic        flag_z, flag_n, flag_c, flag_v;

  int checks = 0, errors = 0;
  logic mz = 0, mn = 0, mc = 0, mv = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #10 clk = ~clk;

  imm_alu dut_i (.clk(clk), .rst_n(rst_n), .sub_op(sub_op), .reg_form(reg_form),
    .op_a(op_a), .op_b(op_b), .imm16(imm16), .imm_hi(imm_hi), .shift_sel(shift_sel),
    .flag_en(flag_en), .result(result), .flag_z(flag_z), .flag_n(flag_n),
    .flag_c(flag_c), .flag_v(flag_v));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (op %0d rf %0d h %0d a %h b %h imm %h)",
               tag, act, exp, sub_op, reg_form, imm_hi, op_a, op_b, imm16);
    end
  endtask

  function automatic void ref_model(input logic [2:0] op, input logic rf,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
      input logic h, input logic [4:0] ss, input logic cf,
      output logic [31:0] r, output logic c, output logic v);
    logic [31:0] bb;
    logic [63:0] u;
    longint s;
    logic brw;
    logic [5:0] amt;
    int n;
    logic ar;
    if (rf) bb = b;
    else begin
      bb = h ? {im, 16'h0} : {16'h0, im};
      if (op == 3'd4) bb = h ? (bb | 32'h0000_ffff) : (bb | 32'hffff_0000);
    end
    c = 0; v = 0; r = 0;
    case (op)
      3'd0, 3'd1: begin
        brw = (op == 3'd1) ? cf : 1'b0;
        u = {32'h0, a} + {32'h0, bb} + {63'h0, brw};
        r = u[31:0]; c = u[32];
        s = longint'($signed(a)) + longint'($signed(bb)) + longint'(brw);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd2, 3'd3: begin
        brw = (op == 3'd3) ? !cf : 1'b0;
        r = a - bb - {31'h0, brw};
        c = ({32'h0, a} >= ({32'h0, bb} + {63'h0, brw}));
        s = longint'($signed(a)) - longint'($signed(bb)) - longint'(brw);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd4: r = a & bb;
      3'd5: r = a | bb;
      3'd6: r = a ^ bb;
      default: begin
        amt = rf ? b[5:0] : im[5:0];
        n = int'($signed(amt));
        ar = rf ? ss[3] : h;
        r = a;
        if (n > 0) for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
        else for (int i = 0; i < -n; i++) begin c = r[0]; r = {ar & r[31], r[31:1]}; end
      end
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op, input logic rf);
    if (!rf && op == 3'd4) return "R5";
    if (!rf && op != 3'd7) return "R4";
    case (op)
      3'd0, 3'd2: return "R1";
      3'd1, 3'd3: return "R2";
      3'd7:       return "R8";
      default:    return "R3";
    endcase
  endfunction

  task automatic step(input string rtag, input string ftag);
    logic [31:0] er;
    logic ec, ev;
    ref_model(sub_op, reg_form, op_a, op_b, imm16, imm_hi, shift_sel, mc, er, ec, ev);
    #1;
    chk(rtag, result, er);
    if (flag_en) begin mz = (er == 0); mn = er[31]; mc = ec; mv = ev; end
    @(posedge clk); #1;
    chk(flag_en ? ftag : "R6", {28'h0, flag_z, flag_n, flag_c, flag_v}, {28'h0, mz, mn, mc, mv});
  endtask

  function automatic logic [31:0] corner(input int k);
    case (k % 8)
      0: return 32'h0000_0000;
      1: return 32'hffff_ffff;
      2: return 32'h8000_0000;
      3: return 32'h7fff_ffff;
      4: return 32'h0000_0001;
      5: return 32'h0000_ffff;
      6: return 32'hffff_0000;
      default: return 32'h5a5a_a5a5;
    endcase
  endfunction

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R6", {28'h0, flag_z, flag_n, flag_c, flag_v}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 7; op++)
      for (int rf = 0; rf < 2; rf++)
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            next_rand();
            sub_op = op[2:0]; reg_form = rf[0]; imm_hi = h[0];
            op_a = (k < 16) ? corner(k) : lfsr;
            next_rand();
            op_b = (k < 16) ? corner(k / 2 + 3) : lfsr;
            imm16 = (k < 16) ? corner(k + 5)[15:0] : lfsr[31:16];
            flag_en = (k % 3 != 1);
            step(op_tag(op[2:0], rf[0]), (op < 4) ? "R7" : "R7");
          end

    for (int rf = 0; rf < 2; rf++)
      for (int ty = 0; ty < 2; ty++)
        for (int n = -31; n <= 31; n++)
          for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            sub_op = 3'd7; reg_form = rf[0];
            shift_sel = ty[0] ? 5'b11000 : 5'b10000;
            imm_hi = rf[0] ? 1'b0 : ty[0];
            op_a = p[0] ? 32'h9e37_79b9 : 32'h4c5a_3e71;
            op_b = rf[0] ? {26'h155_5555, n[5:0]} : 32'hdead_beef;
            imm16 = rf[0] ? 16'h7777 : {10'h2aa, n[5:0]};
            flag_en = 1'b1;
            step((n < 0) ? "R9" : "R8", "R10");
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule